// File: doc/BRIEF.md
# I2C Bus Slave Controller

This block is a slave-only endpoint for a two-wire I2C bus. It watches the synchronised SCL and SDA lines for START and STOP conditions, compares the address byte that follows a START against its own 7-bit or 10-bit address, and then moves data one byte at a time through a single buffer register shared with a local processor. Each received or transmitted byte raises an interrupt flag. Software reads a received byte from the buffer. For a transmitted byte, software loads the buffer and then releases the clock.

The bus pins are open drain. The block never drives a line high. It only asserts a pull-down enable for SCL and for SDA. When a master addresses the block for reading, the block stretches SCL low until software has supplied the byte and released the clock. Reception has flow control: when the previous byte has not been read, or an overflow is still pending, the block withholds the acknowledge.

Top module: `i2c_slave_ctrl`

## Requirements
- R1: START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. With mode 1110 or 1111 each of these events sets the interrupt flag. With mode 0110 or 0111 neither event sets it.
- R2: In 7-bit modes (mode bits 2:0 = 110), the upper seven bits of the address byte are compared with bits 6:0 of the own-address register (select 1), and bit 0 is R/W. On a match the block acknowledges (pulls SDA low for the ninth clock) and stores the byte in the buffer. On a mismatch it does not acknowledge, does not set the flag, and ignores the bus until the next START.
- R3: An address byte that arrives while buffer-full (status bit 0) or overflow (status bit 1) is set is not acknowledged. If buffer-full was set, overflow is set as well.
- R4: The interrupt flag (status bit 2, mirrored on `irq`) is set once for each byte accepted or transmitted. Writing 1 to status bit 2 clears it. After reset the status register reads 0 and `irq` is low.
- R5: Reading the buffer (select 0) clears buffer-full.
- R6: After a matched write address, each data byte is sampled MSB first on SCL rising edges, stored in the buffer with buffer-full set, and acknowledged.
- R7: A data byte that completes while buffer-full is set is not acknowledged. It sets overflow and leaves the buffer unchanged. Writing 1 to status bit 1 clears overflow.
- R8: After acknowledging a read address, the block holds SCL low (status bit 4 reads 1) until software writes the buffer and then writes the control register (select 3, bits 3:0 mode) with bit 4 set. A release written without a buffer write since the hold began is ignored, and control bit 4 keeps reading 0. A master ACK after a transmitted byte starts a new hold. A NACK does not.
- R9: A transmitted byte appears on SDA MSB first, one bit per SCL period.
- R10: In 10-bit modes (mode bits 2:0 = 111), the first byte must be 11110, A9, A8, R/W, with A9:A8 taken from select 2 bits 1:0. The second byte must equal select 1. Each byte is acknowledged when software has read the buffer in between. A read byte 11110, A9, A8, 1 after a repeated START is acknowledged only if the full address matched since the last STOP.
- R11: The block changes its SDA pull-down only while SCL is low.
- R12: When mode bits 2:1 are not 11, the block ignores the bus and never acknowledges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_pull | output | 1 | Pull SCL low when 1 |
| sda_pull | output | 1 | Pull SDA low when 1 |
| cpu_sel | input | 3 | Register select: 0 buffer, 1 address low, 2 address high, 3 control, 4 status |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (reading the buffer clears buffer-full) |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Interrupt flag |

## Verification
The hardest situation to reach is a clock hold in which software tries to release SCL before it has loaded the buffer. This happens only inside a read transfer, so the master model must be blocked on a stretched clock at the same moment software acts. The bench forks the bus master and the processor sequence. The processor polls the hold bit, issues the premature release, confirms that SCL stays low, and only then loads and releases. The 10-bit repeated-start read needs the same kind of coordination: the bench reads the buffer between the address bytes so that neither is refused.

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_pull,
  output logic       sda_pull,
  input  logic [2:0] cpu_sel,
  input  logic       cpu_wr,
  input  logic       cpu_rd,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata,
  output logic       irq
);

  localparam logic [2:0] SEL_BUF = 3'd0;
  localparam logic [2:0] SEL_ADL = 3'd1;
  localparam logic [2:0] SEL_ADH = 3'd2;
  localparam logic [2:0] SEL_CTL = 3'd3;
  localparam logic [2:0] SEL_STA = 3'd4;

  typedef enum logic [2:0] {ST_IDLE, ST_ADR1, ST_ADR2, ST_RX, ST_TX, ST_DONE} st_t;

  logic [SYNC_STAGES-1:0] scl_sy, sda_sy;
  logic scl_s, sda_s, scl_q, sda_q;
  logic scl_rise, scl_fall, start_ev, stop_ev;
  st_t  st, nxt_q, nxt_c;
  logic [3:0] cnt, mode;
  logic [7:0] sr, buf_q, own_lo;
  logic [1:0] own_hi;
  logic ack_ph, mack, bf, ov, irq_f, rw, ckp, tx_ld, rel_pend, hi_ok;
  logic active, ten, ss_irq, rx_st, byte_end, hit, accept;

  assign scl_s    = scl_sy[SYNC_STAGES-1];
  assign sda_s    = sda_sy[SYNC_STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

  assign active = (mode[2:1] == 2'b11);
  assign ten    = mode[0];
  assign ss_irq = mode[3];
  assign rx_st  = (st == ST_ADR1) || (st == ST_ADR2) || (st == ST_RX);
  assign byte_end = scl_fall && !ack_ph && (cnt == 4'd8) && rx_st;
  assign accept   = byte_end && hit && !bf && !ov;
  assign irq = irq_f;

  always_comb begin
    hit   = 1'b0;
    nxt_c = ST_DONE;
    case (st)
      ST_ADR1: begin
        if (!ten) begin
          hit   = (sr[7:1] == own_lo[6:0]);
          nxt_c = sr[0] ? ST_TX : ST_RX;
        end else begin
          hit   = (sr[7:1] == {5'b11110, own_hi}) && (!sr[0] || hi_ok);
          nxt_c = sr[0] ? ST_TX : ST_ADR2;
        end
      end
      ST_ADR2: begin
        hit   = (sr == own_lo);
        nxt_c = ST_RX;
      end
      ST_RX: begin
        hit   = 1'b1;
        nxt_c = ST_RX;
      end
      default: ;
    endcase
  end

  always_comb begin
    case (cpu_sel)
      SEL_BUF: cpu_rdata = buf_q;
      SEL_ADL: cpu_rdata = own_lo;
      SEL_ADH: cpu_rdata = {6'd0, own_hi};
      SEL_CTL: cpu_rdata = {3'd0, ckp, mode};
      SEL_STA: cpu_rdata = {3'd0, scl_pull, rw, irq_f, ov, bf};
      default: cpu_rdata = 8'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1; sda_sy <= '1; scl_q <= 1'b1; sda_q <= 1'b1;
      st <= ST_IDLE; nxt_q <= ST_IDLE;
      cnt <= 4'd0; mode <= 4'd0; sr <= 8'd0; buf_q <= 8'd0;
      own_lo <= 8'd0; own_hi <= 2'd0;
      ack_ph <= 1'b0; mack <= 1'b0; bf <= 1'b0; ov <= 1'b0; irq_f <= 1'b0;
      rw <= 1'b0; ckp <= 1'b0; tx_ld <= 1'b0; rel_pend <= 1'b0; hi_ok <= 1'b0;
      scl_pull <= 1'b0; sda_pull <= 1'b0;
    end else begin
      scl_sy <= {scl_sy[SYNC_STAGES-2:0], scl_in};
      sda_sy <= {sda_sy[SYNC_STAGES-2:0], sda_in};
      scl_q  <= scl_s;
      sda_q  <= sda_s;

      if (rel_pend) begin
        scl_pull <= 1'b0;
        rel_pend <= 1'b0;
      end

      if (cpu_rd && cpu_sel == SEL_BUF) bf <= 1'b0;
      if (cpu_wr) begin
        case (cpu_sel)
          SEL_BUF: begin buf_q <= cpu_wdata; tx_ld <= 1'b1; end
          SEL_ADL: own_lo <= cpu_wdata;
          SEL_ADH: own_hi <= cpu_wdata[1:0];
          SEL_CTL: begin
            mode <= cpu_wdata[3:0];
            if (cpu_wdata[4] && scl_pull && tx_ld && !rel_pend) begin
              ckp      <= 1'b1;
              sr       <= buf_q;
              sda_pull <= ~buf_q[7];
              rel_pend <= 1'b1;
              tx_ld    <= 1'b0;
            end
          end
          SEL_STA: begin
            if (cpu_wdata[1]) ov    <= 1'b0;
            if (cpu_wdata[2]) irq_f <= 1'b0;
          end
          default: ;
        endcase
      end

      if (!active) begin
        st <= ST_IDLE; ack_ph <= 1'b0;
        sda_pull <= 1'b0; scl_pull <= 1'b0;
      end else if (start_ev) begin
        st <= ST_ADR1; cnt <= 4'd0; ack_ph <= 1'b0; sda_pull <= 1'b0;
        if (ss_irq) irq_f <= 1'b1;
      end else if (stop_ev) begin
        st <= ST_IDLE; ack_ph <= 1'b0; sda_pull <= 1'b0; hi_ok <= 1'b0;
        if (ss_irq) irq_f <= 1'b1;
      end else if (scl_rise) begin
        if (ack_ph) begin
          if (st == ST_TX) mack <= ~sda_s;
        end else if (rx_st) begin
          sr  <= {sr[6:0], sda_s};
          cnt <= cnt + 4'd1;
        end else if (st == ST_TX) begin
          cnt <= cnt + 4'd1;
        end
      end else if (scl_fall) begin
        if (ack_ph) begin
          ack_ph <= 1'b0; sda_pull <= 1'b0; cnt <= 4'd0;
          if (st == ST_TX) begin
            irq_f <= 1'b1;
            if (mack) begin
              scl_pull <= 1'b1; ckp <= 1'b0; tx_ld <= 1'b0;
            end else begin
              st <= ST_DONE;
            end
          end else begin
            st <= nxt_q;
            if (nxt_q == ST_TX) begin
              scl_pull <= 1'b1; ckp <= 1'b0; tx_ld <= 1'b0;
            end
          end
        end else if (byte_end) begin
          ack_ph <= 1'b1; cnt <= 4'd0;
          if (accept) begin
            buf_q <= sr; bf <= 1'b1; irq_f <= 1'b1; sda_pull <= 1'b1;
            nxt_q <= nxt_c;
            if (st == ST_ADR1) rw <= sr[0];
            if (st == ST_ADR2) hi_ok <= 1'b1;
          end else begin
            nxt_q <= ST_DONE;
            if (hit && bf) ov <= 1'b1;
          end
        end else if (st == ST_TX && cnt == 4'd8) begin
          sda_pull <= 1'b0; ack_ph <= 1'b1; cnt <= 4'd0; mack <= 1'b0;
        end else if (st == ST_TX) begin
          sr       <= {sr[6:0], 1'b0};
          sda_pull <= ~sr[6];
        end
      end
    end
  end

  assert_nack_when_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ack_ph) && sda_pull) |-> (!$past(bf) && !$past(ov)));

  assert_read_clears_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_sel == SEL_BUF && !accept) |=> !bf);

  assert_overflow_keeps_buffer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ov) && !$past(cpu_wr)) |-> $stable(buf_q));

  assert_hold_needs_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_pull) && active) |-> $past(tx_ld, 2));

  assert_sda_steady_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_q && active) |=> $stable(sda_pull));

endmodule

// File: tb/i2c_slave_ctrl_tb.sv
module i2c_slave_ctrl_tb;
  localparam int HP = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_line, sda_line;
  logic scl_pull, sda_pull;
  logic [2:0] cpu_sel = 3'd0;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0] cpu_wdata = 8'd0;
  logic [7:0] cpu_rdata;
  logic irq;

  int tests = 0, fails = 0, mon_viol = 0;
  logic prev_scl = 1'b1, prev_sdap = 1'b0;

  always #5 clk = ~clk;

  assign scl_line = m_scl & ~scl_pull;
  assign sda_line = m_sda & ~sda_pull;

  i2c_slave_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
    .scl_pull(scl_pull), .sda_pull(sda_pull),
    .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq)
  );

  // R11 monitor: pull-down on SDA stays put across consecutive SCL-high samples
  always @(negedge clk) begin
    if (rst_n && scl_line && prev_scl && (sda_pull != prev_sdap)) mon_viol++;
    prev_scl  <= scl_line;
    prev_sdap <= sda_pull;
  end

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpu_write(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    cpu_sel = s; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [2:0] s, output logic [7:0] d);
    @(negedge clk);
    cpu_sel = s; cpu_rd = 1'b1;
    #1 d = cpu_rdata;
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1; wt(HP);
    m_sda = 1'b0; wt(HP);
    m_scl = 1'b0; wt(HP/2);
  endtask

  task automatic bus_rstart();
    m_sda = 1'b1; wt(HP);
    m_scl = 1'b1;
    while (!scl_line) @(negedge clk);
    wt(HP);
    m_sda = 1'b0; wt(HP);
    m_scl = 1'b0; wt(HP/2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wt(HP);
    m_scl = 1'b1;
    while (!scl_line) @(negedge clk);
    wt(HP);
    m_sda = 1'b1; wt(HP);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    m_sda = b; wt(HP);
    m_scl = 1'b1;
    while (!scl_line) @(negedge clk);
    wt(HP/2);
    r = sda_line;
    wt(HP/2);
    m_scl = 1'b0; wt(HP/2);
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], r);
    clk_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] d);
    logic r;
    d = 8'd0;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, r);
      d = {d[6:0], r};
    end
    clk_bit(~mack, r);
  endtask

  task automatic serve_tx(input logic [7:0] d, input logic [3:0] md);
    logic [7:0] s;
    s = 8'd0;
    while (!s[4]) cpu_read(3'd4, s);
    cpu_read(3'd0, s);
    cpu_write(3'd4, 8'h04);
    cpu_write(3'd0, d);
    cpu_write(3'd3, {4'h1, md});
  endtask

  logic ack;
  logic [7:0] rd, d1, d2;

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wt(4);
    rst_n = 1'b1;
    wt(2);
    // R4 reset state
    cpu_read(3'd4, rd);
    check("R4 reset status", rd, 8'h00);
    check("R4 reset irq", irq, 0);
    check("R8 reset scl pull", scl_pull, 0);

    cpu_write(3'd1, 8'h3A);
    // R12 inactive mode ignores bus
    bus_start(); wr_byte(8'h74, ack); bus_stop();
    check("R12 no ack when inactive", ack, 0);

    // R1 no start interrupt in 0110
    cpu_write(3'd3, 8'h06);
    bus_start();
    check("R1 no start irq in 0110", irq, 0);
    wr_byte(8'h74, ack);
    check("R2 address match ack", ack, 1);
    cpu_read(3'd4, rd);
    check("R4 irq after address", rd[2:0], 3'b101);
    cpu_read(3'd0, rd);
    check("R2 address stored", rd, 8'h74);
    cpu_read(3'd4, rd);
    check("R5 read clears full", rd[0], 0);
    cpu_write(3'd4, 8'h04);
    check("R4 irq cleared", irq, 0);
    wr_byte(8'hA5, ack);
    check("R6 data ack", ack, 1);
    check("R4 irq per byte", irq, 1);
    cpu_write(3'd4, 8'h04);
    wr_byte(8'h5C, ack);
    check("R7 no ack when full", ack, 0);
    check("R4 no irq on refused byte", irq, 0);
    cpu_read(3'd0, rd);
    check("R7 buffer kept", rd, 8'hA5);
    cpu_read(3'd4, rd);
    check("R7 overflow set", rd[1], 1);
    bus_stop();

    // R3 overflow pending refuses address
    bus_start(); wr_byte(8'h74, ack); bus_stop();
    check("R3 no ack with overflow", ack, 0);
    cpu_write(3'd4, 8'h06);
    bus_start(); wr_byte(8'h74, ack); bus_stop();
    check("R3 ack after clear", ack, 1);
    bus_start(); wr_byte(8'h74, ack); bus_stop();
    check("R3 no ack with full", ack, 0);
    cpu_read(3'd4, rd);
    check("R3 overflow from full", rd[1], 1);
    cpu_read(3'd0, rd);
    cpu_write(3'd4, 8'h06);

    // R2 mismatch
    bus_start(); wr_byte(8'h76, ack); bus_stop();
    check("R2 mismatch no ack", ack, 0);
    check("R2 mismatch no irq", irq, 0);

    // R1 start/stop interrupts
    cpu_write(3'd3, 8'h0E);
    bus_start();
    check("R1 start irq", irq, 1);
    cpu_write(3'd4, 8'h04);
    bus_stop();
    check("R1 stop irq", irq, 1);
    cpu_write(3'd4, 8'h04);

    // R8 R9 read transfer with stretching
    cpu_write(3'd3, 8'h06);
    bus_start(); wr_byte(8'h75, ack);
    check("R2 read address ack", ack, 1);
    fork
      rd_byte(1'b1, d1);
      begin
        rd = 8'd0;
        while (!rd[4]) cpu_read(3'd4, rd);
        cpu_read(3'd0, rd);
        cpu_write(3'd4, 8'h04);
        cpu_write(3'd3, 8'h16);
        wt(40);
        check("R8 early release ignored", scl_pull, 1);
        cpu_read(3'd3, rd);
        check("R8 release bit stays 0", rd[4], 0);
        cpu_write(3'd0, 8'hC3);
        cpu_write(3'd3, 8'h16);
      end
    join
    check("R9 first byte", d1, 8'hC3);
    check("R8 hold after master ack", scl_pull, 1);
    check("R4 irq after tx byte", irq, 1);
    fork
      rd_byte(1'b0, d2);
      serve_tx(8'h5A, 4'h6);
    join
    check("R9 second byte", d2, 8'h5A);
    check("R8 no hold after nack", scl_pull, 0);
    bus_stop();
    cpu_write(3'd4, 8'h06);

    // R10 ten-bit addressing
    cpu_write(3'd3, 8'h07);
    cpu_write(3'd2, 8'h02);
    cpu_write(3'd1, 8'h5D);
    bus_start(); wr_byte(8'hF4, ack);
    check("R10 high byte ack", ack, 1);
    cpu_read(3'd0, rd);
    check("R10 high byte stored", rd, 8'hF4);
    wr_byte(8'h5D, ack);
    check("R10 low byte ack", ack, 1);
    cpu_read(3'd0, rd);
    wr_byte(8'h11, ack);
    cpu_read(3'd0, rd);
    check("R6 ten-bit data", rd, 8'h11);
    bus_stop();
    bus_start(); wr_byte(8'hF4, ack); cpu_read(3'd0, rd);
    wr_byte(8'h5E, ack); bus_stop();
    check("R10 wrong low byte", ack, 0);
    bus_start(); wr_byte(8'hF4, ack); cpu_read(3'd0, rd);
    wr_byte(8'h5D, ack); cpu_read(3'd0, rd);
    bus_rstart(); wr_byte(8'hF5, ack);
    check("R10 read after full match", ack, 1);
    fork
      rd_byte(1'b0, d1);
      serve_tx(8'h96, 4'h7);
    join
    check("R10 ten-bit tx", d1, 8'h96);
    bus_stop();
    bus_start(); wr_byte(8'hF5, ack); bus_stop();
    check("R10 read without match", ack, 0);

    check("R11 sda steady while scl high", mon_viol, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule